// File: doc/BRIEF.md
# Dual-Channel PWM Slice with Input Gating

This block is a single pulse-width modulation slice. A 16-bit counter runs from zero up to a programmable period limit and is advanced through a fractional clock divider whose ratio has an 8-bit whole part and a 4-bit sixteenths part. Two compare channels, A and B, each drive an output. An output is active while the counter is below that channel's compare value. Each output can be inverted. The counter can either wrap to zero (trailing-edge mode) or run up to the limit and back down (phase-correct mode).

The B pin can also act as an input. As an input it can let the counter run only while it is high, or advance the counter once per rising or falling edge. Software can shift the phase of the counter by one count in either direction. A wrap event sets a sticky flag, which drives an interrupt line through an enable bit. A force bit can also drive that line.

All configuration enters through a simple register write port. The port takes one write per cycle and never pushes back. Control and status are plain pins.

Top module: `pwm_slice`

## Requirements
- R1: In trailing-edge mode the counter steps from the period limit back to 0 and raises a wrap event. The limit register resets to 0xFFFF, and the counter and both compare values reset to 0.
- R2: Each output equals (counter < compare value) XOR its invert bit. A compare value of 0 therefore holds the output inactive. Both invert bits reset to 0. The invert bits are CTRL bit 2 (A) and bit 3 (B).
- R3: The divider ratio is int + frac/16. The DIV register holds frac in bits [3:0] and int in bits [11:4], and int = 0 counts as 256. Each enabled cycle adds 16 to an accumulator, and a count step happens when the accumulator reaches int*16+frac. It resets to 1.0, and a DIV write clears the accumulator.
- R4: CTRL bits [5:4] select how the divider is advanced. 0 advances it every cycle. 1 advances it while B is high. 2 advances it once per rising edge of B, and 3 once per falling edge. B passes through two synchronizer flops before an edge detector, so it is seen three edges after it is sampled.
- R5: With CTRL bit 1 set (phase-correct), the counter rises to the limit, holds it for one step, falls to 0, and holds 0 for one step. The wrap event occurs on the step that leaves 0, giving a period of 2*(limit+1) steps. The counter changes by at most one per cycle.
- R6: Writes to compare A (address 3), compare B (address 4) and the limit (address 5) go to pending registers. The working copies take the pending values on a wrap event, or on any cycle in which the slice is stopped.
- R7: A wrap event sets the raw flag. Writing 1 to bit 0 at address 7 clears it, and a wrap in the same cycle wins over the clear.
- R8: The interrupt is (raw OR force) AND enable. Address 6 holds enable in bit 0 and force in bit 1. The force bit stays set until software writes it to 0.
- R9: Writing CTRL with bit 6 set queues one extra count step, taken on the first running cycle with no divider step. Writing CTRL with bit 7 set swallows the next divider step. Both are meant for divider ratios above 1.
- R10: CTRL bit 0 runs the slice. While it is 0 the counter holds its value. A write to address 2 loads the counter on the next edge, overriding any step, and cnt_o shows the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 CTRL, 1 DIV, 2 counter, 3 compare A, 4 compare B, 5 limit, 6 interrupt control, 7 status clear) |
| wr_data | input | 16 | Register write data |
| b_in | input | 1 | Asynchronous B pin input for the gate and edge modes |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| cnt_o | output | 16 | Current counter value |
| irq | output | 1 | Wrap interrupt |

## Verification
On every cycle, the in-line assertions check the following. The counter returns to zero after the limit, and it moves by at most one in phase-correct mode. A zero compare value holds its output at the invert level, and a queued retard swallows a step. The divider never ticks on back-to-back cycles above ratio 2, and an edge mode never yields two consecutive advances. The working compare values move only when they are allowed to load, and a stopped counter holds. Forced interrupts stay asserted, and a clear without a wrap drops the flag. Only the bench's cycle-level reference model can show the fractional step spacing, the exact gated and edge-counted sequences behind the synchronizer delay, the phase-correct period, and the deferred take-up of compare and limit writes, because these depend on long histories of input patterns.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

  typedef enum logic [1:0] {
    CM_FREE = 2'd0,
    CM_GATE = 2'd1,
    CM_RISE = 2'd2,
    CM_FALL = 2'd3
  } cnt_mode_e;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_DIV  = 1;
  localparam int unsigned REG_CNT  = 2;
  localparam int unsigned REG_CMPA = 3;
  localparam int unsigned REG_CMPB = 4;
  localparam int unsigned REG_TOP  = 5;
  localparam int unsigned REG_IRQ  = 6;
  localparam int unsigned REG_STAT = 7;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_PC   = 1;
  localparam int unsigned CB_INVA = 2;
  localparam int unsigned CB_INVB = 3;
  localparam int unsigned CB_MODE = 4;
  localparam int unsigned CB_ADV  = 6;
  localparam int unsigned CB_RET  = 7;

endpackage

// File: rtl/pwm_frac_div.sv
module pwm_frac_div #(
  parameter int IW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [IW-1:0] int_i,
  input  logic [FW-1:0] frac_i,
  output logic          tick_o
);
  localparam int RW = IW + FW + 1;
  localparam int SW = RW + 1;

  logic [RW-1:0] ratio;
  logic [SW-1:0] acc_q, sum;

  // whole part 0 stands for the largest ratio
  assign ratio  = {int_i == '0, int_i, frac_i};
  assign sum    = acc_q + SW'(1 << FW);
  assign tick_o = adv_i && (sum >= {1'b0, ratio});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (adv_i) acc_q <= tick_o ? (sum - {1'b0, ratio}) : sum;
  end

  assert_div_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && ratio >= RW'(2 << FW)) |=> (ratio < RW'(2 << FW) || !tick_o));

endmodule

// File: rtl/pwm_in_cond.sv
module pwm_in_cond import pwm_slice_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      b_i,
  input  cnt_mode_e mode_i,
  output logic      en_o
);
  logic s1_q, s2_q, sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      sd_q <= 1'b0;
    end else begin
      s1_q <= b_i;
      s2_q <= s1_q;
      sd_q <= s2_q;
    end
  end

  always_comb begin
    unique case (mode_i)
      CM_FREE: en_o = 1'b1;
      CM_GATE: en_o = s2_q;
      CM_RISE: en_o = s2_q && !sd_q;
      default: en_o = !s2_q && sd_q;
    endcase
  end

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CM_RISE && en_o) |=> (mode_i != CM_RISE || !en_o));
  assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CM_FALL && en_o) |=> (mode_i != CM_FALL || !en_o));

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          updown_i,
  input  logic          tick_i,
  input  logic          adv_req_i,
  input  logic          ret_req_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          down_q, down_nx, wrap_nx;
  logic          pend_adv_q, pend_ret_q, step;

  assign step = run_i && !cnt_wr_i && (tick_i ? !pend_ret_q : pend_adv_q);

  always_comb begin
    cnt_nx  = cnt_q;
    down_nx = down_q;
    wrap_nx = 1'b0;
    if (!updown_i) begin
      down_nx = 1'b0;
      if (cnt_q == top_i) begin
        cnt_nx  = '0;
        wrap_nx = 1'b1;
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end else if (!down_q) begin
      if (cnt_q >= top_i) down_nx = 1'b1;
      else                cnt_nx  = cnt_q + 1'b1;
    end else begin
      if (cnt_q == '0) begin
        down_nx = 1'b0;
        wrap_nx = 1'b1;
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  assign wrap_o = step && wrap_nx;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      down_q     <= 1'b0;
      pend_adv_q <= 1'b0;
      pend_ret_q <= 1'b0;
    end else begin
      if (cnt_wr_i) begin
        cnt_q <= cnt_wdata_i;
      end else if (step) begin
        cnt_q  <= cnt_nx;
        down_q <= down_nx;
      end
      if (adv_req_i)             pend_adv_q <= 1'b1;
      else if (run_i && !tick_i) pend_adv_q <= 1'b0;
      if (ret_req_i)             pend_ret_q <= 1'b1;
      else if (run_i && tick_i)  pend_ret_q <= 1'b0;
    end
  end

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !updown_i && cnt_q == top_i) |=> (cnt_q == '0));
  assert_pc_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && updown_i && !cnt_wr_i) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CW'($past(cnt_q) + 1'b1) ||
       cnt_q == CW'($past(cnt_q) - 1'b1)));
  assert_retard_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_ret_q && tick_i && run_i && !cnt_wr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_slice.sv
module pwm_slice import pwm_slice_pkg::*; #(
  parameter int CW  = 16,
  parameter int DIW = 8,
  parameter int DFW = 4,
  parameter int AW  = 3,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          b_in,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [CW-1:0] cnt_o,
  output logic          irq
);
  localparam logic [CW-1:0] TOP_RST = {CW{1'b1}};

  logic wr_ctrl, wr_div, wr_cnt, wr_ca, wr_cb, wr_top, wr_irq, wr_stat;
  assign wr_ctrl = wr_en && wr_addr == AW'(REG_CTRL);
  assign wr_div  = wr_en && wr_addr == AW'(REG_DIV);
  assign wr_cnt  = wr_en && wr_addr == AW'(REG_CNT);
  assign wr_ca   = wr_en && wr_addr == AW'(REG_CMPA);
  assign wr_cb   = wr_en && wr_addr == AW'(REG_CMPB);
  assign wr_top  = wr_en && wr_addr == AW'(REG_TOP);
  assign wr_irq  = wr_en && wr_addr == AW'(REG_IRQ);
  assign wr_stat = wr_en && wr_addr == AW'(REG_STAT);

  logic           run_q, pc_q, inv_a_q, inv_b_q, ie_q, force_q, raw_q;
  cnt_mode_e      mode_q;
  logic [DIW-1:0] div_int_q;
  logic [DFW-1:0] div_frac_q;
  logic [CW-1:0]  top_pend_q, ca_pend_q, cb_pend_q;
  logic [CW-1:0]  top_act_q, ca_act_q, cb_act_q;
  logic           in_en, tick, wrap, load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      pc_q       <= 1'b0;
      inv_a_q    <= 1'b0;
      inv_b_q    <= 1'b0;
      mode_q     <= CM_FREE;
      div_int_q  <= DIW'(1);
      div_frac_q <= '0;
      ie_q       <= 1'b0;
      force_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q   <= wr_data[CB_RUN];
        pc_q    <= wr_data[CB_PC];
        inv_a_q <= wr_data[CB_INVA];
        inv_b_q <= wr_data[CB_INVB];
        mode_q  <= cnt_mode_e'(wr_data[CB_MODE +: 2]);
      end
      if (wr_div) begin
        div_frac_q <= wr_data[0 +: DFW];
        div_int_q  <= wr_data[DFW +: DIW];
      end
      if (wr_irq) begin
        ie_q    <= wr_data[0];
        force_q <= wr_data[1];
      end
    end
  end

  // compare and limit shadows: pending copy, working copy
  assign load = wrap || !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_pend_q <= TOP_RST;
      ca_pend_q  <= '0;
      cb_pend_q  <= '0;
      top_act_q  <= TOP_RST;
      ca_act_q   <= '0;
      cb_act_q   <= '0;
    end else begin
      if (wr_top) top_pend_q <= wr_data[CW-1:0];
      if (wr_ca)  ca_pend_q  <= wr_data[CW-1:0];
      if (wr_cb)  cb_pend_q  <= wr_data[CW-1:0];
      if (load) begin
        top_act_q <= top_pend_q;
        ca_act_q  <= ca_pend_q;
        cb_act_q  <= cb_pend_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      raw_q <= 1'b0;
    else if (wrap)                   raw_q <= 1'b1;
    else if (wr_stat && wr_data[0])  raw_q <= 1'b0;
  end

  pwm_in_cond u_in_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .b_i    (b_in),
    .mode_i (mode_q),
    .en_o   (in_en)
  );

  pwm_frac_div #(.IW(DIW), .FW(DFW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (wr_div),
    .adv_i  (run_q && in_en),
    .int_i  (div_int_q),
    .frac_i (div_frac_q),
    .tick_o (tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_q),
    .updown_i    (pc_q),
    .tick_i      (tick),
    .adv_req_i   (wr_ctrl && wr_data[CB_ADV]),
    .ret_req_i   (wr_ctrl && wr_data[CB_RET]),
    .cnt_wr_i    (wr_cnt),
    .cnt_wdata_i (wr_data[CW-1:0]),
    .top_i       (top_act_q),
    .cnt_o       (cnt_o),
    .wrap_o      (wrap)
  );

  // B output keeps its compare even when the pin is used as an input
  assign pwm_a = (cnt_o < ca_act_q) ^ inv_a_q;
  assign pwm_b = (cnt_o < cb_act_q) ^ inv_b_q;
  assign irq   = (raw_q || force_q) && ie_q;

  assert_zero_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ca_act_q == '0) |-> (pwm_a == inv_a_q));
  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(ca_act_q) && $stable(top_act_q)));
  assert_raw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[0] && !wrap) |=> !raw_q);
  assert_force_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && ie_q) |-> irq);
  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(cnt_o));

endmodule

// File: tb/pwm_slice_tb.sv
module pwm_slice_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        b_in = 1'b0;
  logic        pwm_a, pwm_b, irq;
  logic [15:0] cnt_o;

  pwm_slice u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .b_in(b_in), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .cnt_o(cnt_o), .irq(irq)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  int m_cnt, m_top, m_ca, m_cb, p_top, p_ca, p_cb, m_acc, m_int, m_frac, m_mode;
  bit m_run, m_pc, m_inva, m_invb, m_dir, m_raw, m_ie, m_force;
  bit m_s1, m_s2, m_sd, m_padv, m_pret;
  int r, ncnt;
  bit cond, tick, step, wrap, load, cwr, ndir;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_top = 65535; m_ca = 0; m_cb = 0;
      p_top = 65535; p_ca = 0; p_cb = 0; m_acc = 0; m_int = 1; m_frac = 0;
      m_mode = 0; m_run = 0; m_pc = 0; m_inva = 0; m_invb = 0; m_dir = 0;
      m_raw = 0; m_ie = 0; m_force = 0; m_s1 = 0; m_s2 = 0; m_sd = 0;
      m_padv = 0; m_pret = 0;
    end else begin
      case (m_mode)
        0:       cond = 1;
        1:       cond = m_s2;
        2:       cond = m_s2 && !m_sd;
        default: cond = !m_s2 && m_sd;
      endcase
      r    = (m_int == 0 ? 256 : m_int) * 16 + m_frac;
      tick = m_run && cond && (m_acc + 16 >= r);
      cwr  = wr_en && wr_addr == 2;
      step = m_run && !cwr && (tick ? !m_pret : m_padv);
      ncnt = m_cnt; ndir = m_dir; wrap = 0;
      if (!m_pc) begin
        ndir = 0;
        if (m_cnt == m_top) begin ncnt = 0; wrap = 1; end
        else ncnt = (m_cnt + 1) % 65536;
      end else if (!m_dir) begin
        if (m_cnt >= m_top) ndir = 1; else ncnt = m_cnt + 1;
      end else begin
        if (m_cnt == 0) begin ndir = 0; wrap = 1; end else ncnt = m_cnt - 1;
      end
      wrap = wrap && step;
      load = wrap || !m_run;
      if (m_run && !tick) m_padv = 0;
      if (m_run && tick)  m_pret = 0;
      if (wr_en && wr_addr == 1) m_acc = 0;
      else if (m_run && cond) m_acc = tick ? m_acc + 16 - r : m_acc + 16;
      if (cwr) m_cnt = wr_data;
      else if (step) begin m_cnt = ncnt; m_dir = ndir; end
      if (load) begin m_top = p_top; m_ca = p_ca; m_cb = p_cb; end
      if (wrap) m_raw = 1;
      else if (wr_en && wr_addr == 7 && wr_data[0]) m_raw = 0;
      m_sd = m_s2; m_s2 = m_s1; m_s1 = b_in;
      if (wr_en) begin
        case (wr_addr)
          0: begin
            m_run = wr_data[0]; m_pc = wr_data[1]; m_inva = wr_data[2];
            m_invb = wr_data[3]; m_mode = wr_data[5:4];
            if (wr_data[6]) m_padv = 1;
            if (wr_data[7]) m_pret = 1;
          end
          1: begin m_frac = wr_data[3:0]; m_int = wr_data[11:4]; end
          3: p_ca = wr_data;
          4: p_cb = wr_data;
          5: p_top = wr_data;
          6: begin m_ie = wr_data[0]; m_force = wr_data[1]; end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ea, eb, ei;
      ea = (m_cnt < m_ca) ^ m_inva;
      eb = (m_cnt < m_cb) ^ m_invb;
      ei = (m_raw || m_force) && m_ie;
      n_cmp++;
      if (cnt_o !== 16'(m_cnt) || pwm_a !== ea || pwm_b !== eb || irq !== ei) begin
        n_bad++;
        $display("FAIL %s cyc %0d: cnt/a/b/irq = %0d/%b/%b/%b expected %0d/%b/%b/%b",
                 cur_req, cyc, cnt_o, pwm_a, pwm_b, irq, m_cnt, ea, eb, ei);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic b_hold(input bit v, input int n);
    b_in = v;
    idle(n);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // reset state: R1 counter 0, R2 outputs inactive, R8 no interrupt
    chk("R1", cnt_o, 0, "reset counter");
    chk("R2", pwm_a, 0, "reset pwm_a");
    chk("R2", pwm_b, 0, "reset pwm_b");
    chk("R8", irq, 0, "reset irq");

    cur_req = "R1";
    wr(5, 9); wr(3, 3); wr(4, 7); wr(6, 1);
    wr(0, 16'h01);
    idle(45);

    cur_req = "R7";
    wr(7, 1);
    idle(5);
    wr(7, 1);
    idle(12);

    cur_req = "R8";
    wr(6, 3);
    idle(6);
    wr(7, 1);
    chk("R8", irq, 1, "force keeps irq high");
    idle(4);
    wr(6, 1);
    idle(4);

    cur_req = "R6";
    idle(3);
    wr(3, 8);
    wr(5, 4);
    idle(30);

    cur_req = "R2";
    wr(0, 16'h05);
    wr(4, 0);
    idle(25);
    wr(3, 0);
    idle(12);
    chk("R2", pwm_a, 1, "zero compare inverted output");
    wr(3, 2); wr(4, 5);

    cur_req = "R3";
    wr(0, 16'h01);
    wr(1, 16'h28);
    idle(60);
    wr(1, 16'h13);
    idle(40);
    wr(1, 16'h00);
    idle(300);

    cur_req = "R9";
    wr(1, 16'h30);
    idle(7);
    wr(0, 16'h41);
    idle(10);
    wr(0, 16'h81);
    idle(10);
    wr(0, 16'h41);
    wr(0, 16'h81);
    idle(12);

    cur_req = "R5";
    wr(1, 16'h10);
    wr(5, 5);
    wr(0, 16'h03);
    idle(50);
    wr(0, 16'h0B);
    wr(3, 4);
    idle(30);
    wr(5, 0);
    idle(10);
    wr(5, 6);

    cur_req = "R4";
    wr(0, 16'h11);
    b_hold(1, 7); b_hold(0, 5); b_hold(1, 3); b_hold(0, 4);
    wr(0, 16'h21);
    for (int i = 0; i < 12; i++) begin b_hold(1, 2); b_hold(0, 2); end
    for (int i = 0; i < 6; i++) begin b_hold(1, 1); b_hold(0, 3); end
    wr(0, 16'h31);
    for (int i = 0; i < 10; i++) begin b_hold(1, 3); b_hold(0, 1); end
    idle(5);

    cur_req = "R10";
    wr(0, 16'h00);
    wr(2, 3);
    chk("R10", cnt_o, 3, "counter load while stopped");
    idle(5);
    chk("R10", cnt_o, 3, "counter held while stopped");
    wr(0, 16'h01);
    idle(4);
    wr(2, 1);
    idle(10);

    idle(2);
    finish_run();
  end

endmodule